// File: doc/BRIEF.md
# Propagation-Delay Shortest Path Engine

This block solves the single-source shortest path problem for a small directed graph with nonnegative integer edge weights. No priority queue is used. Every edge owns a countdown register that is loaded with the edge's weight. A signal spreads outward from a chosen source node. An edge becomes live once its origin node has been reached. It then counts down by one per clock, and when it runs out it marks its destination as reached. The first edge to arrive at a node leaves the index of its origin node behind as that node's predecessor. The set of predecessors forms a shortest-path tree rooted at the source.

The edge table is written through a one-cycle write port while the engine is idle. Each write carries an edge slot index, an origin node, a destination node, a weight and an enable bit. A one-cycle start pulse with a source index begins a run. The run ends with a sticky done flag. Once done is set, the per-node reached bits and predecessor fields can be read. Run time in clocks follows the largest weighted distance from the source, and storage grows linearly with the number of edges.

Top module: `sp_race_engine`

## Requirements
- R1: After reset, busy, done and every reached bit are 0, and every edge slot is disabled.
- R2: In the cycle after start is sampled, busy is 1, done is 0, and only the source is reached. The source's predecessor field reads the source's own index, and every other predecessor field reads 0.
- R3: An enabled edge of weight w at least 1, whose origin became reached t clocks after start, reaches its destination t+w clocks after start. A zero-weight edge does so at t+1. A node's arrival time is the earliest over all edges into it.
- R4: When a node is first reached, its predecessor field (bits n*NB+NB-1 down to n*NB of pred, with NB = clog2 of the node count) takes the origin index of the arriving edge. Later arrivals leave it unchanged.
- R5: If several edges reach an unreached node in the same cycle, the edge in the lowest slot index sets the predecessor.
- R6: Once every node is reached, done rises and busy falls in that same clock, T clocks after start, where T is the largest arrival time.
- R7: If a cycle passes in which no live edge has a nonzero count and no new node is reached, done rises at the end of that cycle. Unreached nodes keep reached 0 and predecessor 0. Done then holds until the next start.
- R8: A start pulse during a run aborts that run. It clears all reached bits, reloads every counter from its stored weight, and begins again from the new source.
- R9: An edge slot written with enable 0 never reaches its destination.
- R10: Reached bits never clear during a run, edge counters never increase during a run, and no reached bit changes while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one edge slot this cycle |
| cfg_edge | input | clog2(N_EDGES) | Edge slot to write |
| cfg_from | input | clog2(N_NODES) | Origin node of the edge |
| cfg_to | input | clog2(N_NODES) | Destination node of the edge |
| cfg_weight | input | W_BITS | Edge weight |
| cfg_enable | input | 1 | 1 makes the slot a real edge |
| start | input | 1 | Begin (or restart) a run |
| start_node | input | clog2(N_NODES) | Source node of the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results valid |
| reached | output | N_NODES | Per-node reached bit |
| pred | output | N_NODES*clog2(N_NODES) | Packed per-node predecessor indices |

## Verification
The assertions rely on three conditions. The edge table is written only while no run is in progress. The source index is always a valid node. A write to the table never lands in the same cycle as a start pulse. The bench respects all three. It changes the table only after done is seen or before the first start, and it draws source indices only from the node range. A restart is issued mid-run without touching the table. The restart case checks that the counters reload from their stored weights and that the earlier source's partial progress leaves no trace.

// File: rtl/sp_race_engine.sv
module sp_race_engine #(
  parameter int N_NODES = 8,
  parameter int N_EDGES = 16,
  parameter int W_BITS  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [$clog2(N_EDGES)-1:0]           cfg_edge,
  input  logic [$clog2(N_NODES)-1:0]           cfg_from,
  input  logic [$clog2(N_NODES)-1:0]           cfg_to,
  input  logic [W_BITS-1:0]                    cfg_weight,
  input  logic                                 cfg_enable,
  input  logic                                 start,
  input  logic [$clog2(N_NODES)-1:0]           start_node,
  output logic                                 busy,
  output logic                                 done,
  output logic [N_NODES-1:0]                   reached,
  output logic [N_NODES*$clog2(N_NODES)-1:0]   pred
);
  localparam int NB = $clog2(N_NODES);
  localparam int EB = $clog2(N_EDGES);

  logic [NB-1:0]      e_from [N_EDGES];
  logic [NB-1:0]      e_to   [N_EDGES];
  logic [W_BITS-1:0]  e_w    [N_EDGES];
  logic [W_BITS-1:0]  cnt    [N_EDGES];
  logic [N_EDGES-1:0] e_en;

  logic [N_EDGES-1:0] live, pend, fire;
  logic [N_NODES-1:0] hit, nxt_reached, reached_q;
  logic [NB-1:0]      hit_src [N_NODES];
  logic [NB-1:0]      pred_q  [N_NODES];
  logic               busy_q, done_q, progress, finish;

  for (genvar g = 0; g < N_EDGES; g++) begin : g_edge
    assign live[g] = e_en[g] & reached_q[e_from[g]];
    assign pend[g] = live[g] & (cnt[g] != '0);
    assign fire[g] = live[g] & (cnt[g] <= W_BITS'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_EDGES; e++) begin
        e_en[e]   <= 1'b0;
        e_from[e] <= '0;
        e_to[e]   <= '0;
        e_w[e]    <= '0;
        cnt[e]    <= '0;
      end
    end else begin
      for (int e = 0; e < N_EDGES; e++) begin
        if (cfg_we && cfg_edge == EB'(e)) begin
          e_en[e]   <= cfg_enable;
          e_from[e] <= cfg_from;
          e_to[e]   <= cfg_to;
          e_w[e]    <= cfg_weight;
        end
        if (start)
          cnt[e] <= e_w[e];
        else if (busy_q && pend[e])
          cnt[e] <= cnt[e] - 1'b1;
      end
    end
  end

  always_comb begin
    for (int n = 0; n < N_NODES; n++) begin
      hit[n]     = 1'b0;
      hit_src[n] = '0;
      for (int e = N_EDGES - 1; e >= 0; e--) begin
        if (fire[e] && e_to[e] == NB'(n)) begin
          hit[n]     = 1'b1;
          hit_src[n] = e_from[e];
        end
      end
    end
  end

  assign nxt_reached = reached_q | hit;
  assign progress    = (|pend) | (|(hit & ~reached_q));
  assign finish      = busy_q & ((&nxt_reached) | !progress);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      reached_q <= '0;
      for (int n = 0; n < N_NODES; n++) pred_q[n] <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      for (int n = 0; n < N_NODES; n++) begin
        reached_q[n] <= (NB'(n) == start_node);
        pred_q[n]    <= (NB'(n) == start_node) ? start_node : '0;
      end
    end else if (busy_q) begin
      reached_q <= nxt_reached;
      for (int n = 0; n < N_NODES; n++)
        if (hit[n] && !reached_q[n]) pred_q[n] <= hit_src[n];
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign reached = reached_q;
  for (genvar g = 0; g < N_NODES; g++) begin : g_pred
    assign pred[g*NB +: NB] = pred_q[g];
  end

  a_r2_source_seeded: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && !done_q && $onehot(reached_q) && reached_q[$past(start_node)]
              && pred_q[$past(start_node)] == $past(start_node));

  a_r6_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start |=> done_q);

  a_r10_reached_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !start |=> (reached_q & $past(reached_q)) == $past(reached_q));

  a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> $stable(reached_q));

  for (genvar g = 0; g < N_NODES; g++) begin : g_pred_chk
    a_r4_pred_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !start && reached_q[g] |=> pred_q[g] == $past(pred_q[g]));
  end

  for (genvar g = 0; g < N_EDGES; g++) begin : g_cnt_chk
    a_r10_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !start |=> cnt[g] <= $past(cnt[g]));
  end
endmodule

// File: tb/test_sp_race_engine.sv
module test_sp_race_engine;
  localparam int N = 8;
  localparam int M = 16;
  localparam int W = 8;
  localparam int NB = 3;
  localparam int EB = 4;
  localparam int INF = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, start = 1'b0;
  logic [EB-1:0] cfg_edge = '0;
  logic [NB-1:0] cfg_from = '0, cfg_to = '0, start_node = '0;
  logic [W-1:0] cfg_weight = '0;
  logic busy, done;
  logic [N-1:0] reached;
  logic [N*NB-1:0] pred;

  always #10 clk = ~clk;

  sp_race_engine #(.N_NODES(N), .N_EDGES(M), .W_BITS(W)) i_sp_race_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_edge(cfg_edge),
    .cfg_from(cfg_from), .cfg_to(cfg_to), .cfg_weight(cfg_weight),
    .cfg_enable(cfg_enable), .start(start), .start_node(start_node),
    .busy(busy), .done(done), .reached(reached), .pred(pred));

  typedef struct { string req; string what; int idx; int exp; } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  int bf[M], bt[M], bw[M];
  bit be[M];

  always @(posedge clk) cyc <= start ? 0 : cyc + 1;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_edge(int e, int f, int t, int w, bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_edge = EB'(e); cfg_from = NB'(f); cfg_to = NB'(t);
    cfg_weight = W'(w); cfg_enable = en;
    bf[e] = f; bt[e] = t; bw[e] = w; be[e] = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_graph();
    for (int e = 0; e < M; e++) put_edge(e, 0, 0, 0, 1'b0);
  endtask

  task automatic expect_run(int src, string req);
    int d[N];
    int p, t, mx, c;
    bit all;
    for (int n = 0; n < N; n++) d[n] = INF;
    d[src] = 0;
    for (int k = 0; k <= N; k++)
      for (int e = 0; e < M; e++)
        if (be[e] && d[bf[e]] < INF) begin
          c = d[bf[e]] + (bw[e] > 0 ? bw[e] : 1);
          if (c < d[bt[e]]) d[bt[e]] = c;
        end
    all = 1'b1; mx = 0;
    for (int n = 0; n < N; n++) begin
      p = 0;
      if (n == src) p = src;
      else if (d[n] < INF) begin
        for (int e = M - 1; e >= 0; e--)
          if (be[e] && bt[e] == n && d[bf[e]] < INF &&
              d[bf[e]] + (bw[e] > 0 ? bw[e] : 1) == d[n]) p = bf[e];
      end
      if (d[n] < INF) begin if (d[n] > mx) mx = d[n]; end
      else all = 1'b0;
      sbq.push_back('{req, "reached", n, (d[n] < INF) ? 1 : 0});
      sbq.push_back('{req, "pred", n, p});
    end
    if (all) t = mx;
    else begin
      t = mx;
      for (int e = 0; e < M; e++)
        if (be[e] && d[bf[e]] < INF && d[bf[e]] + bw[e] > t) t = d[bf[e]] + bw[e];
      t = t + 1;
    end
    sbq.push_back('{req, "cycles", src, t});
  endtask

  task automatic go(int src);
    @(negedge clk);
    start = 1'b1; start_node = NB'(src);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    bit prev = 1'b0;
    item_t it;
    int act;
    forever begin
      @(posedge clk); #1;
      if (done && !prev) begin
        if (sbq.size() < 2 * N + 1) chk("R6", "unexpected done, queued items", sbq.size(), 2 * N + 1);
        else
          for (int k = 0; k < 2 * N + 1; k++) begin
            it = sbq.pop_front();
            if (it.what == "reached") act = int'(reached[it.idx]);
            else if (it.what == "pred") act = int'(pred[it.idx*NB +: NB]);
            else act = cyc;
            chk(it.req, $sformatf("%s node %0d", it.what, it.idx), act, it.exp);
          end
      end
      prev = done;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    for (int e = 0; e < M; e++) begin bf[e] = 0; bt[e] = 0; bw[e] = 0; be[e] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "reached", int'(reached), 0);
    rst_n = 1'b1;
    // R1 slots disabled after reset: a run from node 2 must stall with only node 2 reached
    expect_run(2, "R1");
    go(2);
    // R2 seed state one cycle after start
    chk("R2", "busy", int'(busy), 1);
    chk("R2", "reached", int'(reached), 1 << 2);
    chk("R2", "pred src", int'(pred[2*NB +: NB]), 2);
    chk("R2", "pred other", int'(pred[0 +: NB]), 0);
    wait_drain();

    // R3/R4/R6: weighted graph where detours beat direct edges
    put_edge(0, 0, 1, 3, 1); put_edge(1, 0, 2, 1, 1); put_edge(2, 2, 1, 1, 1);
    put_edge(3, 1, 3, 2, 1); put_edge(4, 2, 3, 5, 1); put_edge(5, 3, 4, 1, 1);
    put_edge(6, 4, 5, 2, 1); put_edge(7, 5, 6, 1, 1); put_edge(8, 6, 7, 3, 1);
    put_edge(9, 7, 0, 1, 1);
    expect_run(0, "R6");
    go(0); wait_drain();
    chk("R6", "busy after done", int'(busy), 0);

    // R9: disable the detour edge
    put_edge(2, 2, 1, 1, 0);
    expect_run(0, "R9");
    go(0); wait_drain();

    // R8: restart mid-run from another source, counters partly spent
    put_edge(2, 2, 1, 1, 1);
    go(0);
    repeat (4) @(negedge clk);
    expect_run(5, "R8");
    go(5); wait_drain();

    // R5: simultaneous arrivals, lowest slot wins
    clear_graph();
    put_edge(3, 0, 1, 2, 1); put_edge(5, 0, 2, 1, 1); put_edge(6, 2, 1, 1, 1);
    put_edge(1, 2, 3, 4, 1); put_edge(0, 1, 3, 3, 1); put_edge(7, 3, 4, 1, 1);
    put_edge(8, 4, 5, 1, 1); put_edge(9, 5, 6, 1, 1); put_edge(10, 6, 7, 1, 1);
    expect_run(0, "R5");
    go(0); wait_drain();
    chk("R5", "pred node1", int'(pred[1*NB +: NB]), 0);
    chk("R5", "pred node3", int'(pred[3*NB +: NB]), 1);

    // R3: zero-weight edges take one clock
    clear_graph();
    put_edge(0, 0, 1, 0, 1); put_edge(1, 1, 2, 0, 1); put_edge(2, 0, 2, 1, 1);
    put_edge(3, 2, 3, 0, 1); put_edge(4, 3, 4, 2, 1); put_edge(5, 4, 5, 0, 1);
    put_edge(6, 5, 6, 0, 1); put_edge(7, 6, 7, 0, 1);
    expect_run(0, "R3");
    go(0); wait_drain();

    // R7: unreachable nodes, stall after last pending counter drains
    clear_graph();
    put_edge(0, 0, 1, 2, 1); put_edge(1, 1, 2, 3, 1); put_edge(2, 0, 3, 6, 1);
    put_edge(3, 2, 0, 9, 1); put_edge(4, 4, 5, 1, 1); put_edge(5, 0, 4, 1, 0);
    expect_run(0, "R7");
    go(0); wait_drain();
    chk("R7", "done held", int'(done), 1);
    chk("R7", "reached node4", int'(reached[4]), 0);

    // R3/R4: generated graphs
    for (int r = 0; r < 30; r++) begin
      for (int e = 0; e < M; e++)
        put_edge(e, $urandom_range(0, N - 1), $urandom_range(0, N - 1),
                 $urandom_range(0, 12), $urandom_range(0, 4) != 0);
      begin
        int s;
        s = $urandom_range(0, N - 1);
        expect_run(s, (r % 2 == 0) ? "R3" : "R4");
        go(s); wait_drain();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule